// File: doc/BRIEF.md
# Floating-point / integer register bit-transfer unit

This block moves raw bit patterns between the floating-point register domain and the integer register domain. It does no arithmetic conversion. There are four operations. Two 64-bit copies, one in each direction, pass all bits through unchanged. A 32-bit transfer toward the integer side narrows the double-precision register image to a single-precision pattern, the same way a single-precision store does. A 32-bit transfer toward the floating-point side widens a single-precision pattern to double precision, the same way a single-precision load does. None of the four raises an exception or sets a floating-point flag.

When the record bit is set, the unit also produces a condition-register field update. If the destination is an integer register, the result is tested as a signed 64-bit integer and the update targets field 0. If the destination is a floating-point register, the update targets field 1 and carries the four floating-point status summary bits supplied on an input. The register files sit outside the unit. Results appear one clock after the request.

Top module: `fpr_gpr_xfer`

## Requirements
- R1: Op code 2'b00 (float to integer, 64-bit) and op code 2'b10 (integer to float, 64-bit) return the 64-bit source unchanged. Op bit 1 set means the destination is a floating-point register.
- R2: Op code 2'b01 (float to integer, 32-bit) works on doubles with a biased exponent above 896, or with all bits except the sign zero. Result bits [31:30] take source bits [63:62], result bits [29:0] take source bits [58:29], and result bits [63:32] are zero. Lower source bits are dropped without rounding.
- R3: For op 2'b01 with a biased exponent from 1 to 896, the result is the sign bit, eight zero exponent bits, and the low 23 bits of {1, source[51:29]} shifted right by (897 - exponent). There is no rounding, so an exponent below 874 gives a signed zero.
- R4: Op code 2'b11 (integer to float, 32-bit) reads only source bits [31:0] as a single-precision value. If that value is not denormal, the result is {s[31:30], three copies of the inverse of s[30] (or of s[30] itself when the exponent field is 0 or 255), s[29:0], 29 zeros}.
- R5: For op 2'b11 with a zero exponent field and a nonzero fraction whose leading one sits at bit p, the result is a normal double. Its biased exponent is 874+p, and its fraction is the single fraction shifted left by 23-p, with the leading one removed and 29 zeros appended.
- R6: With the record bit set and an integer destination, the unit writes field 0 (cr_sel=0). The value cr_val = {LT, GT, EQ, SO} is taken from the signed 64-bit result, with SO copied from so_in.
- R7: With the record bit set and a floating-point destination, the unit writes field 1 (cr_sel=1) with cr_val equal to fp_stat. so_in has no effect.
- R8: With the record bit clear, cr_wr stays low while the result is still produced.
- R9: During reset, out_valid, result, cr_wr, cr_sel and cr_val are all zero.
- R10: out_valid goes high exactly one cycle after in_valid. When no request is present, result and the condition outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| op | input | 2 | Operation code (see R1 to R5) |
| rec | input | 1 | Record bit: request a condition field update |
| src | input | 64 | Source operand |
| so_in | input | 1 | Integer summary-overflow bit for the field 0 update |
| fp_stat | input | 4 | Floating-point status summary bits for the field 1 update |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Transferred bit pattern |
| cr_wr | output | 1 | Condition field write enable |
| cr_sel | output | 1 | 0 selects field 0, 1 selects field 1 |
| cr_val | output | 4 | Condition field value |

## Verification
The bench exercises the edges of the narrowing path:
- the largest denormal exponent (896);
- the smallest exponent (874) that still leaves one fraction bit;
- an exponent below 874 with the sign set;
- an all-ones fraction that must truncate instead of round.

A design that rounds, shifts by one position too few or too many, or loses the sign would return the wrong single pattern. On the widening side, the bench sends single denormals with the leading one at the top and at the bottom of the fraction, plus infinity, NaN and signed zero. A wrong priority encoder or a wrong choice of exponent-fill bits would show up as a wrong exponent. For the condition field, the bench checks that a narrowed negative float records GT (its 64-bit image is positive), that SO follows so_in only for integer destinations, and that the record-clear path never writes.

// File: rtl/fgx_pkg.sv
package fgx_pkg;
  localparam int XLEN      = 64;
  localparam int SPW       = 32;
  localparam int DEXP_W    = 11;
  localparam int SEXP_W    = 8;
  localparam int DMAN_W    = 52;
  localparam int SMAN_W    = 23;
  localparam int DBIAS     = 1023;
  localparam int SBIAS     = 127;
  localparam int CR_W      = 4;
  // lowest double exponent that maps to a normal single
  localparam int MIN_NORM_DEXP = DBIAS - SBIAS + 1;
  // lowest double exponent that keeps one single fraction bit
  localparam int MIN_DEN_DEXP  = MIN_NORM_DEXP - SMAN_W;
  localparam int PAD_W     = DMAN_W - SMAN_W;
  localparam int SEXP_MAX  = (1 << SEXP_W) - 1;

  typedef enum logic [1:0] {
    OP_F2G64 = 2'b00,
    OP_F2G32 = 2'b01,
    OP_G2F64 = 2'b10,
    OP_G2F32 = 2'b11
  } xfer_op_e;
endpackage

// File: rtl/fgx_narrow.sv
module fgx_narrow
  import fgx_pkg::*;
(
  input  logic [XLEN-1:0] dbl,
  output logic [SPW-1:0]  sgl
);
  localparam int TOP_LO = DMAN_W + SEXP_W - 1 - (SPW - 2);

  logic [DEXP_W-1:0] dexp;
  logic [DEXP_W:0]   shamt;
  logic [SMAN_W:0]   mant_in;
  logic [SMAN_W:0]   mant_sh;
  logic              keep_direct;

  always_comb begin
    dexp        = dbl[XLEN-2 -: DEXP_W];
    keep_direct = (dexp > DEXP_W'(MIN_NORM_DEXP - 1)) || (dbl[XLEN-2:0] == '0);
    shamt       = (DEXP_W+1)'(MIN_NORM_DEXP) - {1'b0, dexp};
    mant_in     = {1'b1, dbl[DMAN_W-1 -: SMAN_W]};
    mant_sh     = mant_in >> shamt;
    if (keep_direct)
      sgl = {dbl[XLEN-1:XLEN-2], dbl[TOP_LO + SPW - 3 : TOP_LO]};
    else
      sgl = {dbl[XLEN-1], {SEXP_W{1'b0}}, mant_sh[SMAN_W-1:0]};
  end
endmodule

// File: rtl/fgx_widen.sv
module fgx_widen
  import fgx_pkg::*;
(
  input  logic [SPW-1:0]  sgl,
  output logic [XLEN-1:0] dbl
);
  logic [SEXP_W-1:0] sexp;
  logic [SMAN_W-1:0] frac;
  logic [4:0]        lead;
  logic [SMAN_W-1:0] nfrac;
  logic [DEXP_W-1:0] nexp;
  logic [2:0]        fill;

  always_comb begin
    sexp = sgl[SPW-2 -: SEXP_W];
    frac = sgl[SMAN_W-1:0];
    lead = '0;
    for (int i = 0; i < SMAN_W; i++)
      if (frac[i]) lead = 5'(i);
    nfrac = frac << (5'(SMAN_W) - lead);
    nexp  = DEXP_W'(MIN_DEN_DEXP) + DEXP_W'(lead);
    if (sexp == '0 || sexp == SEXP_W'(SEXP_MAX))
      fill = {3{sgl[SPW-2]}};
    else
      fill = {3{~sgl[SPW-2]}};
    if (sexp == '0 && frac != '0)
      dbl = {sgl[SPW-1], nexp, nfrac, {PAD_W{1'b0}}};
    else
      dbl = {sgl[SPW-1:SPW-2], fill, sgl[SPW-3:0], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/fgx_cr.sv
module fgx_cr
  import fgx_pkg::*;
(
  input  logic            dest_fpr,
  input  logic [XLEN-1:0] res,
  input  logic            so_in,
  input  logic [CR_W-1:0] fp_stat,
  output logic [CR_W-1:0] cr_val
);
  logic is_zero, is_neg;

  always_comb begin
    is_zero = (res == '0);
    is_neg  = res[XLEN-1];
    if (dest_fpr)
      cr_val = fp_stat;
    else
      cr_val = {is_neg, ~is_neg & ~is_zero, is_zero, so_in};
  end
endmodule

// File: rtl/fpr_gpr_xfer.sv
module fpr_gpr_xfer
  import fgx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op,
  input  logic            rec,
  input  logic [63:0]     src,
  input  logic            so_in,
  input  logic [3:0]      fp_stat,
  output logic            out_valid,
  output logic [63:0]     result,
  output logic            cr_wr,
  output logic            cr_sel,
  output logic [3:0]      cr_val
);
  logic [SPW-1:0]  narrow_w;
  logic [XLEN-1:0] widen_w;
  logic [XLEN-1:0] res_nxt;
  logic [CR_W-1:0] cr_nxt;
  logic            dest_fpr;

  fgx_narrow u_narrow (.dbl(src), .sgl(narrow_w));
  fgx_widen  u_widen  (.sgl(src[SPW-1:0]), .dbl(widen_w));

  always_comb begin
    dest_fpr = op[1];
    unique case (xfer_op_e'(op))
      OP_F2G32: res_nxt = {{(XLEN-SPW){1'b0}}, narrow_w};
      OP_G2F32: res_nxt = widen_w;
      default:  res_nxt = src;
    endcase
  end

  fgx_cr u_cr (
    .dest_fpr (dest_fpr),
    .res      (res_nxt),
    .so_in    (so_in),
    .fp_stat  (fp_stat),
    .cr_val   (cr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cr_wr     <= 1'b0;
      cr_sel    <= 1'b0;
      cr_val    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_nxt;
        cr_wr  <= rec;
        cr_sel <= dest_fpr;
        cr_val <= cr_nxt;
      end
    end
  end

  // R1: 64-bit copies pass the source through
  a_r1_copy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op[0] |=> result == $past(src));
  // R2: narrowed result leaves the high word clear
  a_r2_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'b01 |=> result[63:32] == '0);
  // R3: exponent too small for any single fraction bit gives a signed zero
  a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'b01 && src[62:52] < 11'd874 |=> result[30:0] == '0);
  // R4: widened single never has bits below the single fraction
  a_r4_low_pad: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'b11 |=> result[28:0] == '0);
  // R6 / R7: record targets the field chosen by destination type
  a_r6_sel: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rec |=> cr_wr && cr_sel == $past(op[1]));
  // R7: floating destination copies the status summary
  a_r7_stat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rec && op[1] |=> cr_val == $past(fp_stat));
  // R8: no record, no write
  a_r8_no_rec: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !rec |=> !cr_wr);
  // R10: idle cycles hold the result
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result));
endmodule

// File: tb/fpr_gpr_xfer_bench.sv
module fpr_gpr_xfer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        rec = 1'b0;
  logic [63:0] src = '0;
  logic        so_in = 1'b0;
  logic [3:0]  fp_stat = '0;
  logic        out_valid, cr_wr, cr_sel;
  logic [63:0] result;
  logic [3:0]  cr_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpr_gpr_xfer u_fpr_gpr_xfer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rec(rec),
    .src(src), .so_in(so_in), .fp_stat(fp_stat), .out_valid(out_valid),
    .result(result), .cr_wr(cr_wr), .cr_sel(cr_sel), .cr_val(cr_val)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic        rec;
    logic        so;
    logic [3:0]  st;
    logic [63:0] src;
    logic [63:0] res;
    logic        wr;
    logic        sel;
    logic [3:0]  cr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    // R1 copies
    '{4'd1, 2'b00, 1'b0, 1'b0, 4'h0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 4'h0},
    '{4'd1, 2'b10, 1'b0, 1'b0, 4'h0, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b0, 4'h0},
    // R2 narrowing, normal / inf / zero / truncation
    '{4'd2, 2'b01, 1'b0, 1'b0, 4'h0, 64'h3FF0_1000_0000_0000, 64'h0000_0000_3F80_8000, 1'b0, 1'b0, 4'h0},
    '{4'd2, 2'b01, 1'b0, 1'b0, 4'h0, 64'h7FF0_0000_0000_0000, 64'h0000_0000_7F80_0000, 1'b0, 1'b0, 4'h0},
    '{4'd2, 2'b01, 1'b0, 1'b0, 4'h0, 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd2, 2'b01, 1'b0, 1'b0, 4'h0, 64'h3FF0_0000_1FFF_FFFF, 64'h0000_0000_3F80_0000, 1'b0, 1'b0, 4'h0},
    // R3 denormal narrowing
    '{4'd3, 2'b01, 1'b0, 1'b0, 4'h0, 64'h3800_0000_0000_0000, 64'h0000_0000_0040_0000, 1'b0, 1'b0, 4'h0},
    '{4'd3, 2'b01, 1'b0, 1'b0, 4'h0, 64'h36A0_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 4'h0},
    '{4'd3, 2'b01, 1'b0, 1'b0, 4'h0, 64'hB690_0000_0000_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd3, 2'b01, 1'b0, 1'b0, 4'h0, 64'h37FF_FFFF_FFFF_FFFF, 64'h0000_0000_003F_FFFF, 1'b0, 1'b0, 4'h0},
    // R4 widening, upper source word ignored
    '{4'd4, 2'b11, 1'b0, 1'b0, 4'h0, 64'h0000_0000_3F80_8000, 64'h3FF0_1000_0000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd4, 2'b11, 1'b0, 1'b0, 4'h0, 64'hFFFF_FFFF_BF80_0000, 64'hBFF0_0000_0000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd4, 2'b11, 1'b0, 1'b0, 4'h0, 64'h0000_0000_7F80_0000, 64'h7FF0_0000_0000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd4, 2'b11, 1'b0, 1'b0, 4'h0, 64'h0000_0000_FFC0_0000, 64'hFFF8_0000_0000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd4, 2'b11, 1'b0, 1'b0, 4'h0, 64'h1234_5678_8000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 4'h0},
    // R5 single denormals
    '{4'd5, 2'b11, 1'b0, 1'b0, 4'h0, 64'h0000_0000_0000_0001, 64'h36A0_0000_0000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd5, 2'b11, 1'b0, 1'b0, 4'h0, 64'h0000_0000_0040_0000, 64'h3800_0000_0000_0000, 1'b0, 1'b0, 4'h0},
    '{4'd5, 2'b11, 1'b0, 1'b0, 4'h0, 64'h0000_0000_8060_0000, 64'hB808_0000_0000_0000, 1'b0, 1'b0, 4'h0},
    // R6 integer destination records {LT,GT,EQ,SO}
    '{4'd6, 2'b00, 1'b1, 1'b1, 4'hF, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, 4'b1001},
    '{4'd6, 2'b00, 1'b1, 1'b0, 4'hF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 4'b0010},
    '{4'd6, 2'b01, 1'b1, 1'b0, 4'h0, 64'hBFF0_0000_0000_0000, 64'h0000_0000_BF80_0000, 1'b1, 1'b0, 4'b0100},
    // R7 floating destination records fp_stat
    '{4'd7, 2'b11, 1'b1, 1'b0, 4'hA, 64'h0000_0000_3F80_0000, 64'h3FF0_0000_0000_0000, 1'b1, 1'b1, 4'b1010},
    '{4'd7, 2'b10, 1'b1, 1'b1, 4'h0, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_1234, 1'b1, 1'b1, 4'b0000},
    // R8 record clear with inputs that would otherwise record
    '{4'd8, 2'b00, 1'b0, 1'b1, 4'hF, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 4'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] o, input logic r, input logic s,
                      input logic [3:0] st, input logic [63:0] d);
    @(negedge clk);
    op = o; rec = r; so_in = s; fp_stat = st; src = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0 && cr_wr == 1'b0, "R9 valid/wr in reset", {62'b0, out_valid, cr_wr}, 64'h0);
    chk(result == '0 && cr_val == '0 && cr_sel == 1'b0, "R9 data in reset", result, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      send(TBL[k].op, TBL[k].rec, TBL[k].so, TBL[k].st, TBL[k].src);
      chk(out_valid == 1'b1, $sformatf("R10 valid vec %0d", k), {63'b0, out_valid}, 64'h1);
      chk(result == TBL[k].res, $sformatf("R%0d result vec %0d", TBL[k].rq, k), result, TBL[k].res);
      chk(cr_wr == TBL[k].wr, $sformatf("R%0d cr_wr vec %0d", TBL[k].rq, k), {63'b0, cr_wr}, {63'b0, TBL[k].wr});
      if (TBL[k].wr)
        chk(cr_sel == TBL[k].sel && cr_val == TBL[k].cr,
            $sformatf("R%0d cr sel/val vec %0d", TBL[k].rq, k),
            {59'b0, cr_sel, cr_val}, {59'b0, TBL[k].sel, TBL[k].cr});
    end

    // R10: idle cycles with changing inputs leave the outputs alone
    send(2'b00, 1'b1, 1'b0, 4'h0, 64'h0000_0000_0000_0055);
    held = result;
    @(negedge clk);
    op = 2'b11; src = 64'hDEAD_BEEF_0000_0001; rec = 1'b1; fp_stat = 4'hF;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 idle valid low", {63'b0, out_valid}, 64'h0);
    chk(result == held, "R10 idle result held", result, held);
    chk(cr_wr == 1'b1 && cr_sel == 1'b0 && cr_val == 4'b0100, "R10 idle cr held",
        {59'b0, cr_sel, cr_val}, {59'b0, 1'b0, 4'b0100});

    // R9: reset mid-run clears everything
    send(2'b10, 1'b1, 1'b0, 4'h7, 64'hAAAA_5555_AAAA_5555);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0 && cr_wr == 1'b0 && result == '0 && cr_val == '0,
        "R9 async reset clears", result, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 after reset release
    send(2'b10, 1'b0, 1'b0, 4'h0, 64'h1111_2222_3333_4444);
    chk(result == 64'h1111_2222_3333_4444, "R1 copy after reset", result, 64'h1111_2222_3333_4444);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule